// File: doc/BRIEF.md
# EEPROM Program/Erase Protection Gate

This block sits between the command side of an EEPROM and its array controller. Every requested operation (read, byte program, block erase, bulk erase) arrives with a target address, or with a flag that selects the non-volatile configuration register instead of the array. The gate classifies the target, applies the protection policy, and either grants the operation by issuing a one-cycle start strobe to the array controller or rejects it. A rejection also sets a sticky violation flag that software clears by writing 1. After a grant the gate accepts nothing more until the array controller reports completion.

Protection depends on a one-time protect bit in the configuration register, where 1 means open and 0 means armed. The armed state loads from that bit at reset. It becomes set the cycle after a granted program of the register that writes 0 into the bit, and only a reset clears it again. While armed, the 16-byte secured window at 0x08F0..0x08FF and the configuration register cannot be programmed or erased. Block and bulk erase are refused everywhere. Byte programs to the open ranges and all reads still go through.

The controller is a four-state machine. IDLE accepts a request (`req_ready` high). From IDLE, a request that passes the policy goes to GRANT and one that fails goes to REJECT. GRANT lasts one cycle, drives the start strobe and then goes to BUSY. BUSY waits for `arr_done` and then goes back to IDLE. REJECT lasts one cycle and goes back to IDLE.

Top module: `eeprom_guard`

## Requirements
- R1: During reset `prot_armed` loads the inverse of `nvr_prot_bit`. After reset, `req_ready` is 1, `viol_flag` is 0, and `resp_grant`, `resp_reject` and `arr_start` are 0.
- R2: A request accepted while `req_ready` is 1 gives exactly one one-cycle pulse, either `resp_grant` or `resp_reject`, on the cycle after the request. A grant carries `arr_start` together with the request's op, register select, address and data on `arr_op`, `arr_cfg`, `arr_addr` and `arr_data`.
- R3: From a decision until the cycle after `arr_done` (grant), or for the one cycle after a reject, `req_ready` is 0. Requests presented while `req_ready` is 0 are dropped and produce no response and no flag change.
- R4: Ops are encoded 0 = read, 1 = byte program, 2 = block erase, 3 = bulk erase. While armed, any op other than read that targets an address in 0x08F0..0x08FF is rejected. While not armed, such ops are granted.
- R5: A read is granted whenever it targets the configuration register (`req_cfg` = 1) or an array address in 0x0800..0x09FF, armed or not. A read to any other address is rejected.
- R6: While armed, any op other than read with `req_cfg` = 1 is rejected. While not armed, it is granted.
- R7: While armed, block and bulk erase (ops 2 and 3) are rejected at every array address, and byte programs to 0x0800..0x08EF and 0x0900..0x09FF are granted. While not armed, both erases are granted inside 0x0800..0x09FF.
- R8: Any op other than read, with `req_cfg` = 0 and an address outside 0x0800..0x09FF, is rejected whatever the armed state.
- R9: A granted byte program of the configuration register with data bit 0 equal to 0 sets `prot_armed` one cycle after the grant pulse. With data bit 0 equal to 1 it leaves `prot_armed` unchanged. Only reset ever clears `prot_armed`.
- R10: A reject sets `viol_flag` in the same cycle as `resp_reject` and never raises `arr_start`. Writing 1 on `viol_clr` clears the flag on the next cycle. If a reject and a clear arrive on the same edge, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nvr_prot_bit | input | 1 | Stored protect bit, loaded during reset (0 = armed) |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (0 read, 1 program, 2 block erase, 3 bulk erase) |
| req_cfg | input | 1 | 1 = target is the configuration register |
| req_addr | input | 16 | Target array address |
| req_data | input | 8 | Program data |
| req_ready | output | 1 | Gate idle and able to accept a request |
| resp_grant | output | 1 | One-cycle grant pulse |
| resp_reject | output | 1 | One-cycle reject pulse |
| arr_start | output | 1 | Start strobe to the array controller |
| arr_op | output | 2 | Granted operation code |
| arr_cfg | output | 1 | Granted register select |
| arr_addr | output | 16 | Granted address |
| arr_data | output | 8 | Granted program data |
| arr_done | input | 1 | Array controller finished the granted operation |
| prot_armed | output | 1 | Protection armed state |
| viol_flag | output | 1 | Sticky violation flag |
| viol_clr | input | 1 | Write 1 to clear `viol_flag` |

## Verification
The violation flag has two sources that can hit the same clock edge: the setting path from a rejected request and the software clear on `viol_clr`. The bench drives a request that will be rejected in the same cycle as a clear pulse, and then expects the flag to read 1. A clear issued alone on a later cycle must bring the flag to 0. The bench also checks that a request held during GRANT and BUSY leaves the flag and the response lines alone, so that a dropped request cannot race the clear path.

// File: rtl/eeg_pkg.sv
package eeg_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_BULK  = 2'd3
    } eeg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_REJECT = 2'd2,
        ST_BUSY   = 2'd3
    } eeg_state_e;

    function automatic logic is_modify(input eeg_op_e op);
        return op != OP_READ;
    endfunction

    function automatic logic is_wide_erase(input eeg_op_e op);
        return (op == OP_BLOCK) || (op == OP_BULK);
    endfunction

endpackage

// File: rtl/eeg_addr_class.sv
module eeg_addr_class #(
    parameter int unsigned           ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]     ARR_FIRST = 16'h0800,
    parameter logic [ADDR_W-1:0]     ARR_LAST  = 16'h09FF,
    parameter logic [ADDR_W-1:0]     SEC_FIRST = 16'h08F0,
    parameter int unsigned           SEC_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_array,
    output logic              in_secure
);
    localparam logic [ADDR_W-1:0] SEC_LAST = SEC_FIRST + ADDR_W'(SEC_BYTES - 1);

    always_comb begin
        in_array  = (addr >= ARR_FIRST) && (addr <= ARR_LAST);
        in_secure = (addr >= SEC_FIRST) && (addr <= SEC_LAST);
    end
endmodule

// File: rtl/eeg_policy.sv
module eeg_policy
    import eeg_pkg::*;
(
    input  eeg_op_e op,
    input  logic    is_cfg,
    input  logic    in_array,
    input  logic    in_secure,
    input  logic    armed,
    output logic    allow
);
    always_comb begin
        allow = 1'b0;
        if (!is_modify(op)) begin
            allow = is_cfg || in_array;
        end else if (is_cfg) begin
            allow = !armed;
        end else if (!in_array) begin
            allow = 1'b0;
        end else if (is_wide_erase(op)) begin
            allow = !armed;
        end else begin
            allow = !(armed && in_secure);
        end
    end
endmodule

// File: rtl/eeg_ctrl.sv
module eeg_ctrl
    import eeg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned PROT_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  eeg_op_e           req_op,
    input  logic              req_cfg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              allow,
    input  logic              arr_done,
    output logic              req_ready,
    output logic              resp_grant,
    output logic              resp_reject,
    output logic              arr_start,
    output eeg_op_e           arr_op,
    output logic              arr_cfg,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              arm_set,
    output logic              viol_set
);
    eeg_state_e        state_q, state_d;
    eeg_op_e           cap_op;
    logic              cap_cfg;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = allow ? ST_GRANT : ST_REJECT;
            ST_GRANT:  state_d = ST_BUSY;
            ST_REJECT: state_d = ST_IDLE;
            ST_BUSY:   if (arr_done) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_op   <= OP_READ;
            cap_cfg  <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else if (accept) begin
            cap_op   <= req_op;
            cap_cfg  <= req_cfg;
            cap_addr <= req_addr;
            cap_data <= req_data;
        end
    end

    always_comb begin
        req_ready   = 1'b0;
        resp_grant  = 1'b0;
        resp_reject = 1'b0;
        arr_start   = 1'b0;
        arm_set     = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_GRANT: begin
                resp_grant = 1'b1;
                arr_start  = 1'b1;
                arm_set    = (cap_op == OP_PROG) && cap_cfg && !cap_data[PROT_BIT];
            end
            ST_REJECT: resp_reject = 1'b1;
            ST_BUSY:   ;
        endcase
        viol_set = accept && !allow;
        arr_op   = cap_op;
        arr_cfg  = cap_cfg;
        arr_addr = cap_addr;
        arr_data = cap_data;
    end
endmodule

// File: rtl/eeg_status.sv
module eeg_status (
    input  logic clk,
    input  logic rst_n,
    input  logic nvr_prot_bit,
    input  logic arm_set,
    input  logic viol_set,
    input  logic viol_clr,
    output logic prot_armed,
    output logic viol_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)       prot_armed <= ~nvr_prot_bit;
        else if (arm_set) prot_armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        viol_flag <= 1'b0;
        else if (viol_set) viol_flag <= 1'b1;
        else if (viol_clr) viol_flag <= 1'b0;
    end
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
    import eeg_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       PROT_BIT  = 0,
    parameter logic [ADDR_W-1:0] ARR_FIRST = 16'h0800,
    parameter logic [ADDR_W-1:0] ARR_LAST  = 16'h09FF,
    parameter logic [ADDR_W-1:0] SEC_FIRST = 16'h08F0,
    parameter int unsigned       SEC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nvr_prot_bit,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_cfg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              resp_grant,
    output logic              resp_reject,
    output logic              arr_start,
    output logic [1:0]        arr_op,
    output logic              arr_cfg,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    input  logic              arr_done,
    output logic              prot_armed,
    output logic              viol_flag,
    input  logic              viol_clr
);
    eeg_op_e op_in;
    eeg_op_e op_out;
    logic    in_array, in_secure, allow, arm_set, viol_set;

    assign op_in  = eeg_op_e'(req_op);
    assign arr_op = op_out;

    eeg_addr_class #(
        .ADDR_W(ADDR_W), .ARR_FIRST(ARR_FIRST), .ARR_LAST(ARR_LAST),
        .SEC_FIRST(SEC_FIRST), .SEC_BYTES(SEC_BYTES)
    ) u_class (
        .addr(req_addr), .in_array(in_array), .in_secure(in_secure)
    );

    eeg_policy u_policy (
        .op(op_in), .is_cfg(req_cfg), .in_array(in_array),
        .in_secure(in_secure), .armed(prot_armed), .allow(allow)
    );

    eeg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_BIT(PROT_BIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_in),
        .req_cfg(req_cfg), .req_addr(req_addr), .req_data(req_data),
        .allow(allow), .arr_done(arr_done), .req_ready(req_ready),
        .resp_grant(resp_grant), .resp_reject(resp_reject),
        .arr_start(arr_start), .arr_op(op_out), .arr_cfg(arr_cfg),
        .arr_addr(arr_addr), .arr_data(arr_data),
        .arm_set(arm_set), .viol_set(viol_set)
    );

    eeg_status u_status (
        .clk(clk), .rst_n(rst_n), .nvr_prot_bit(nvr_prot_bit),
        .arm_set(arm_set), .viol_set(viol_set), .viol_clr(viol_clr),
        .prot_armed(prot_armed), .viol_flag(viol_flag)
    );
endmodule

// File: rtl/eeprom_guard_chk.sv
module eeprom_guard_chk #(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] ARR_FIRST = 16'h0800,
    parameter logic [ADDR_W-1:0] ARR_LAST  = 16'h09FF,
    parameter logic [ADDR_W-1:0] SEC_FIRST = 16'h08F0,
    parameter int unsigned       SEC_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              req_cfg,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              resp_grant,
    input logic              resp_reject,
    input logic              arr_start,
    input logic              prot_armed,
    input logic              viol_flag
);
    localparam logic [ADDR_W-1:0] SEC_END = SEC_FIRST + ADDR_W'(SEC_BYTES - 1);

    logic take, hit_arr, hit_sec;
    assign take    = req_ready && req_valid;
    assign hit_arr = (req_addr >= ARR_FIRST) && (req_addr <= ARR_LAST);
    assign hit_sec = (req_addr >= SEC_FIRST) && (req_addr <= SEC_END);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_grant, resp_reject}));

    a_r2_decide_next: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (resp_grant || resp_reject));

    a_r3_resp_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_grant || resp_reject) |-> $past(take));

    a_r4_window_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (take && prot_armed && !req_cfg && req_op != 2'd0 && hit_sec) |=> resp_reject);

    a_r5_read_open: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 2'd0 && (req_cfg || hit_arr)) |=> resp_grant);

    a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (take && prot_armed && req_cfg && req_op != 2'd0) |=> resp_reject);

    a_r9_armed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(prot_armed));

    a_r10_reject_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        resp_reject |-> !arr_start);

    a_r10_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        resp_reject |-> viol_flag);
endmodule

bind eeprom_guard eeprom_guard_chk #(
    .ADDR_W(ADDR_W), .ARR_FIRST(ARR_FIRST), .ARR_LAST(ARR_LAST),
    .SEC_FIRST(SEC_FIRST), .SEC_BYTES(SEC_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_cfg(req_cfg), .req_addr(req_addr), .req_ready(req_ready),
    .resp_grant(resp_grant), .resp_reject(resp_reject),
    .arr_start(arr_start), .prot_armed(prot_armed), .viol_flag(viol_flag)
);

// File: tb/eeprom_guard_tb.sv
module eeprom_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nvr_prot_bit = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_cfg = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_data = 8'h0;
    logic        req_ready, resp_grant, resp_reject, arr_start, arr_cfg;
    logic [1:0]  arr_op;
    logic [15:0] arr_addr;
    logic [7:0]  arr_data;
    logic        arr_done = 1'b0;
    logic        prot_armed, viol_flag;
    logic        viol_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    int spurious = 0;
    logic model_armed = 1'b0;
    bit   done = 1'b0;

    typedef struct packed {
        logic        grant;
        logic [1:0]  op;
        logic        cfg;
        logic [15:0] addr;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    eeprom_guard u_dut (
        .clk(clk), .rst_n(rst_n), .nvr_prot_bit(nvr_prot_bit),
        .req_valid(req_valid), .req_op(req_op), .req_cfg(req_cfg),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .resp_grant(resp_grant), .resp_reject(resp_reject),
        .arr_start(arr_start), .arr_op(arr_op), .arr_cfg(arr_cfg),
        .arr_addr(arr_addr), .arr_data(arr_data), .arr_done(arr_done),
        .prot_armed(prot_armed), .viol_flag(viol_flag), .viol_clr(viol_clr)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic model_allow(input logic [1:0] op, input logic cfg,
                                         input logic [15:0] a, input logic armed);
        logic in_arr, in_sec;
        in_arr = (a >= 16'h0800) && (a <= 16'h09FF);
        in_sec = (a >= 16'h08F0) && (a <= 16'h08FF);
        if (op == 2'd0)      return cfg || in_arr;
        if (cfg)             return !armed;
        if (!in_arr)         return 1'b0;
        if (op >= 2'd2)      return !armed;
        return !(armed && in_sec);
    endfunction

    // Array controller stand-in: completes two cycles after a start.
    initial begin
        forever begin
            @(negedge clk);
            if (arr_start) begin
                @(negedge clk);
                @(negedge clk);
                arr_done = 1'b1;
                @(negedge clk);
                arr_done = 1'b0;
            end
        end
    end

    // Monitor: pops the scoreboard on every response.
    initial begin
        forever begin
            @(negedge clk);
            if (resp_grant || resp_reject) begin
                if (exp_q.size() == 0) begin
                    spurious++;
                    chk(1'b0, "R3", "response with nothing pending", 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(resp_grant == e.grant, t, "grant", resp_grant, e.grant);
                    chk(arr_start == e.grant, "R2", "start strobe", arr_start, e.grant);
                    if (e.grant) begin
                        chk(arr_addr == e.addr && arr_op == e.op && arr_cfg == e.cfg,
                            "R2", "granted target", {arr_cfg, arr_op, arr_addr},
                            {e.cfg, e.op, e.addr});
                    end else begin
                        chk(viol_flag == 1'b1, "R10", "flag on reject", viol_flag, 1);
                    end
                end
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic cfg, input logic [15:0] a,
                         input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.grant = model_allow(op, cfg, a, model_armed);
        e.op = op; e.cfg = cfg; e.addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_op = op; req_cfg = cfg; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        if (e.grant && op == 2'd1 && cfg && !d[0]) model_armed = 1'b1;
    endtask

    task automatic clear_viol();
        @(negedge clk); viol_clr = 1'b1;
        @(negedge clk); viol_clr = 1'b0;
        chk(viol_flag == 1'b0, "R10", "flag after clear", viol_flag, 0);
    endtask

    task automatic do_reset(input logic bitv);
        rst_n = 1'b0; nvr_prot_bit = bitv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_armed = ~bitv;
        @(negedge clk);
        chk(prot_armed == ~bitv, "R1", "armed after reset", prot_armed, ~bitv);
        chk(req_ready && !viol_flag && !resp_grant && !resp_reject && !arr_start,
            "R1", "idle outputs", {req_ready, viol_flag, resp_grant, resp_reject, arr_start},
            5'b10000);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        // open part
        issue(2'd1, 1'b0, 16'h08F0, 8'h5A, "R4");
        issue(2'd2, 1'b0, 16'h0850, 8'h00, "R7");
        issue(2'd3, 1'b0, 16'h0900, 8'h00, "R7");
        issue(2'd0, 1'b0, 16'h08FF, 8'h00, "R5");
        issue(2'd1, 1'b0, 16'h0A00, 8'h11, "R8");
        issue(2'd0, 1'b0, 16'h0700, 8'h00, "R5");
        clear_viol();

        // dropped request while the gate is busy
        begin
            exp_t e;
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            e.grant = 1'b1; e.op = 2'd0; e.cfg = 1'b0; e.addr = 16'h0800;
            exp_q.push_back(e); tag_q.push_back("R3");
            req_valid = 1'b1; req_op = 2'd0; req_cfg = 1'b0; req_addr = 16'h0800;
            @(negedge clk);
            chk(req_ready == 1'b0, "R3", "ready during grant", req_ready, 0);
            req_op = 2'd3; req_addr = 16'h0A00;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            chk(viol_flag == 1'b0, "R3", "flag after dropped request", viol_flag, 0);
            chk(spurious == 0, "R3", "extra responses", spurious, 0);
        end

        // arming
        issue(2'd1, 1'b1, 16'h0000, 8'hFF, "R9");
        chk(prot_armed == 1'b0, "R9", "program with bit 1", prot_armed, 0);
        issue(2'd1, 1'b1, 16'h0000, 8'hFE, "R9");
        chk(prot_armed == 1'b1, "R9", "program with bit 0", prot_armed, 1);

        // armed part
        issue(2'd1, 1'b0, 16'h08F0, 8'h01, "R4");
        issue(2'd1, 1'b0, 16'h08FF, 8'h01, "R4");
        issue(2'd2, 1'b0, 16'h08F5, 8'h00, "R4");
        issue(2'd0, 1'b0, 16'h08F7, 8'h00, "R5");
        issue(2'd1, 1'b0, 16'h08EF, 8'h22, "R7");
        issue(2'd1, 1'b0, 16'h0900, 8'h33, "R7");
        issue(2'd2, 1'b0, 16'h0800, 8'h00, "R7");
        issue(2'd3, 1'b0, 16'h09FF, 8'h00, "R7");
        issue(2'd1, 1'b1, 16'h0000, 8'hFF, "R6");
        issue(2'd2, 1'b1, 16'h0000, 8'h00, "R6");
        issue(2'd0, 1'b1, 16'h0000, 8'h00, "R6");
        issue(2'd1, 1'b0, 16'h0A00, 8'h44, "R8");
        chk(prot_armed == 1'b1, "R9", "armed persists", prot_armed, 1);
        clear_viol();

        // reject and clear on the same edge
        begin
            exp_t e;
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            e.grant = 1'b0; e.op = 2'd1; e.cfg = 1'b0; e.addr = 16'h0B00;
            exp_q.push_back(e); tag_q.push_back("R10");
            req_valid = 1'b1; req_op = 2'd1; req_cfg = 1'b0; req_addr = 16'h0B00;
            viol_clr = 1'b1;
            @(negedge clk);
            req_valid = 1'b0; viol_clr = 1'b0;
            chk(viol_flag == 1'b1, "R10", "set beats clear", viol_flag, 1);
            chk(resp_reject && !arr_start, "R10", "reject without start",
                {resp_reject, arr_start}, 2'b10);
        end
        clear_viol();

        do_reset(1'b0);
        issue(2'd1, 1'b0, 16'h08F3, 8'h00, "R4");
        issue(2'd1, 1'b0, 16'h0810, 8'h00, "R7");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "pending responses", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule